// File: doc/BRIEF.md
# Sampled Resonant Bridge Gate Controller

This block decides, once per digitized tank-current sample, whether the bridge of a resonant converter is switched on or off. Its only switching output is one gate bit. Because the stream is expected to carry roughly two hundred samples per resonant period, the bit itself is the drive waveform. No timer or modulator sits between the decision and the bridge.

A burst opens with an open-loop start pulse of programmable length. No current is flowing yet, so nothing can be predicted at that point. Every later edge comes from a first-order IIR predictor. The predictor extrapolates the current ahead of the raw sample, so the bridge commutes early by an amount set by a lead coefficient. A small dead band around zero keeps noise from causing extra edges. When the burst request is withdrawn, the bridge opens at the next predicted falling crossing. A per-sample magnitude check against a threshold opens the bridge at once and latches a fault. The filter normally runs without pause. A mode input can instead hold its state while no burst is running, so the next burst starts from the history of the last one.

Top module: `resgate_drive`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `gateOut` and `faultOut` are both 0.
- R2: `gateOut` changes only on the clock edge that takes a sample with `sampleValid` high. On every other edge it holds.
- R3: In idle, the first valid sample taken with `burstEn` high starts a burst. `gateOut` is 1 after that edge and stays 1 for `startLen` valid samples, whatever their value. A `startLen` of 0 counts as 1.
- R4: After the start pulse, each valid sample drives `gateOut` to 1 when the prediction is greater than +HYST and to 0 when it is less than -HYST. Inside the band the gate holds.
- R5: With `x` the sign-extended sample (12-bit two's complement) and `lp` the filter state, `d = x - lp`, the prediction is `x + ((leadCoef * d) >>> 8)` with `leadCoef` unsigned. The update is `lp <= lp + (d >>> K_SHIFT)`. The arithmetic is 16-bit signed and saturating, and the shifts round toward minus infinity. `lp` resets to 0.
- R6: A valid sample with |x| >= `limitThr` (unsigned) forces `gateOut` to 0 on that edge in any state. If `burstEn` is high, it also sets `faultOut` to 1.
- R7: While `faultOut` is 1 and `burstEn` stays high, the gate stays 0 and no new burst starts. `faultOut` returns to 0 on the edge after a cycle with `burstEn` low.
- R8: When `burstEn` is low during the start pulse or the run, the gate never rises again. It falls on the first valid sample whose prediction is below -HYST, and the block then returns to idle. If the gate is already 0, the block goes to idle at once.
- R9: With `freezeOnStop` high, the filter state does not change on samples taken while the block is idle or faulted.
- R10: With `freezeOnStop` low, the filter state updates on every valid sample, including those taken between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Marks a new sample on `sampleIn` |
| sampleIn | input | 12 | Tank-current sample, signed two's complement |
| burstEn | input | 1 | Burst request; low also clears the fault |
| freezeOnStop | input | 1 | 1: hold the filter state between bursts |
| startLen | input | 16 | Start-pulse length in samples |
| leadCoef | input | 8 | Unsigned lead gain, scaled by 1/256 |
| limitThr | input | 12 | Unsigned current-limit magnitude |
| gateOut | output | 1 | Bridge gate command |
| faultOut | output | 1 | Latched over-current flag |

## Verification
The bench builds the block with the default widths (12-bit samples, 16-bit accumulator, 8-bit coefficient, 16-bit start counter), K_SHIFT of 3 and HYST of 16. A filter shift of 3 lets the state follow a triangle wave of 20 to 60 samples per period closely enough that the lead term and the sign decisions move within a few samples. Bursts of a few hundred samples therefore cover start, run, stop and fault many times. The small dead band means the noise added on top of the waveform actually reaches the hysteresis edges. Random start lengths up to 30 and thresholds placed just below the wave amplitude bring both the end of the start pulse and the limit trip into every kind of state.

// File: rtl/resgate_pkg.sv
package resgate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_FAULT = 3'd4
  } burstState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lpUpdate;
  } dpCtrl_t;

  // per-sample decisions from datapath to control
  typedef struct packed {
    logic predPos;
    logic predNeg;
    logic overLimit;
  } dpStat_t;

endpackage

// File: rtl/resgate_dp.sv
module resgate_dp
  import resgate_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 16,
  parameter int COEF_W   = 8,
  parameter int K_SHIFT  = 3,
  parameter int HYST     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [COEF_W-1:0]   leadCoef,
  input  logic        [SAMPLE_W-1:0] limitThr,
  input  dpCtrl_t                    ctrl,
  output dpStat_t                    stat
);

  localparam int WIDE_W     = ACC_W + COEF_W + 2;
  localparam int LEAD_SHIFT = COEF_W;
  localparam logic signed [WIDE_W-1:0] ACC_MAX = {{(WIDE_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] ACC_MIN = ~ACC_MAX;
  localparam logic signed [ACC_W-1:0]  HYST_P  = ACC_W'(HYST);
  localparam logic signed [ACC_W-1:0]  HYST_N  = -HYST_P;

  function automatic logic signed [ACC_W-1:0] satAcc(input logic signed [WIDE_W-1:0] v);
    if (v > ACC_MAX)      return ACC_MAX[ACC_W-1:0];
    else if (v < ACC_MIN) return ACC_MIN[ACC_W-1:0];
    else                  return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0]    lp;
  logic signed [WIDE_W-1:0]   xWide;
  logic signed [WIDE_W-1:0]   lpWide;
  logic signed [ACC_W-1:0]    diff;
  logic signed [WIDE_W-1:0]   diffWide;
  logic signed [WIDE_W-1:0]   coefWide;
  logic signed [WIDE_W-1:0]   leadProd;
  logic signed [ACC_W-1:0]    lpNext;
  logic signed [ACC_W-1:0]    pred;
  logic signed [SAMPLE_W:0]   xShort;
  logic        [SAMPLE_W:0]   xMag;

  always_comb begin
    xWide    = WIDE_W'(sampleIn);
    lpWide   = WIDE_W'(lp);
    diff     = satAcc(xWide - lpWide);
    diffWide = WIDE_W'(diff);
    lpNext   = satAcc(lpWide + (diffWide >>> K_SHIFT));
    coefWide = $signed({{(WIDE_W-COEF_W){1'b0}}, leadCoef});
    leadProd = coefWide * diffWide;
    pred     = satAcc(xWide + (leadProd >>> LEAD_SHIFT));
  end

  always_comb begin
    xShort = (SAMPLE_W+1)'(sampleIn);
    xMag   = xShort[SAMPLE_W] ? $unsigned(-xShort) : $unsigned(xShort);
  end

  assign stat.predPos   = pred > HYST_P;
  assign stat.predNeg   = pred < HYST_N;
  assign stat.overLimit = xMag >= {1'b0, limitThr};

  always_ff @(posedge clk) begin
    if (!rstN)              lp <= '0;
    else if (ctrl.lpUpdate) lp <= lpNext;
  end

  // the filter moves toward the sample and never past it
  AST_LP_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lpUpdate && (xWide >= lpWide) |=> (lp >= $past(lp)) && (WIDE_W'(lp) <= $past(xWide))); // R5
  AST_LP_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.lpUpdate && (xWide < lpWide) |=> (lp <= $past(lp)) && (WIDE_W'(lp) >= $past(xWide))); // R5
  AST_LP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.lpUpdate |=> $stable(lp)); // R9

endmodule

// File: rtl/resgate_fsm.sv
module resgate_fsm
  import resgate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             burstEn,
  input  logic             freezeOnStop,
  input  logic [CNT_W-1:0] startLen,
  input  dpStat_t          stat,
  output dpCtrl_t          ctrl,
  output logic             gateOut,
  output logic             faultOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  burstState_t      state, stateNxt;
  logic             gateReg, gateNxt;
  logic             faultReg, faultNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [CNT_W-1:0] pulseLen;
  logic             idleLike;

  assign pulseLen = (startLen == '0) ? CNT_ONE : startLen;
  assign idleLike = (state == ST_IDLE) || (state == ST_FAULT);
  assign ctrl.lpUpdate = sampleValid && !(freezeOnStop && idleLike);

  always_comb begin
    stateNxt = state;
    gateNxt  = gateReg;
    faultNxt = faultReg;
    cntNxt   = cnt;
    if (!burstEn) faultNxt = 1'b0;
    if ((state == ST_FAULT) && !burstEn) stateNxt = ST_IDLE;
    if (sampleValid) begin
      if (stat.overLimit) begin
        gateNxt = 1'b0;
        if (burstEn) begin
          faultNxt = 1'b1;
          stateNxt = ST_FAULT;
        end else begin
          stateNxt = ST_IDLE;
        end
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (burstEn) begin
              stateNxt = ST_START;
              gateNxt  = 1'b1;
              cntNxt   = CNT_ONE;
            end
          end
          ST_START, ST_RUN: begin
            if (!burstEn) begin
              stateNxt = ST_STOP;
              if (!gateReg || stat.predNeg) begin
                gateNxt  = 1'b0;
                stateNxt = ST_IDLE;
              end
            end else if ((state == ST_RUN) || (cnt >= pulseLen)) begin
              stateNxt = ST_RUN;
              if (stat.predPos)      gateNxt = 1'b1;
              else if (stat.predNeg) gateNxt = 1'b0;
            end else begin
              cntNxt = cnt + CNT_ONE;
            end
          end
          ST_STOP: begin
            if (!gateReg || stat.predNeg) begin
              gateNxt  = 1'b0;
              stateNxt = ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gateReg  <= 1'b0;
      faultReg <= 1'b0;
      cnt      <= '0;
    end else begin
      state    <= stateNxt;
      gateReg  <= gateNxt;
      faultReg <= faultNxt;
      cnt      <= cntNxt;
    end
  end

  assign gateOut  = gateReg;
  assign faultOut = faultReg;

  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(gateOut)); // R2
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START) |-> gateOut); // R3
  AST_RUN_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (state == ST_RUN) && burstEn && stat.predNeg |=> !gateOut); // R4
  AST_LIMIT_CUTS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && stat.overLimit |=> !gateOut); // R6
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && stat.overLimit && burstEn |=> faultOut); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultOut && burstEn |=> faultOut && !gateOut); // R7
  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !burstEn |=> !faultOut); // R7
  AST_STOP_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |=> !$rose(gateOut)); // R8
  AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    freezeOnStop && (state == ST_IDLE) |-> !ctrl.lpUpdate); // R9

endmodule

// File: rtl/resgate_drive.sv
module resgate_drive
  import resgate_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 16,
  parameter int COEF_W   = 8,
  parameter int CNT_W    = 16,
  parameter int K_SHIFT  = 3,
  parameter int HYST     = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       burstEn,
  input  logic                       freezeOnStop,
  input  logic        [CNT_W-1:0]    startLen,
  input  logic        [COEF_W-1:0]   leadCoef,
  input  logic        [SAMPLE_W-1:0] limitThr,
  output logic                       gateOut,
  output logic                       faultOut
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  resgate_dp #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .COEF_W(COEF_W),
    .K_SHIFT(K_SHIFT), .HYST(HYST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .leadCoef(leadCoef),
    .limitThr(limitThr), .ctrl(dpCtrl), .stat(dpStat)
  );

  resgate_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .burstEn(burstEn),
    .freezeOnStop(freezeOnStop), .startLen(startLen), .stat(dpStat),
    .ctrl(dpCtrl), .gateOut(gateOut), .faultOut(faultOut)
  );

endmodule

// File: tb/resgate_drive_tb.sv
module resgate_drive_tb;

  localparam int CLK_PERIOD = 10;
  localparam int K_SHIFT    = 3;
  localparam int HYST       = 16;
  localparam int WATCH_CYC  = 150000;

  localparam int M_IDLE = 0, M_START = 1, M_RUN = 2, M_STOP = 3, M_FAULT = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              sampleValid;
  logic signed [11:0] sampleIn;
  logic              burstEn;
  logic              freezeOnStop;
  logic [15:0]       startLen;
  logic [7:0]        leadCoef;
  logic [11:0]       limitThr;
  logic              gateOut;
  logic              faultOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  resgate_drive #(.K_SHIFT(K_SHIFT), .HYST(HYST)) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .burstEn(burstEn), .freezeOnStop(freezeOnStop), .startLen(startLen),
    .leadCoef(leadCoef), .limitThr(limitThr), .gateOut(gateOut), .faultOut(faultOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  int mState, mCnt, mLp;
  bit mGate, mFault;

  function automatic int sat16(int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic modelStep(bit v, int x, bit en);
    int d, pred, mag, len, nS, nC, nLp;
    bit pp, pn, ov, nG, nF;
    d    = sat16(x - mLp);
    pred = sat16(x + ((int'(leadCoef) * d) >>> 8));
    pp   = pred > HYST;
    pn   = pred < -HYST;
    mag  = (x < 0) ? -x : x;
    ov   = mag >= int'(limitThr);
    len  = (startLen == 0) ? 1 : int'(startLen);
    nS = mState; nG = mGate; nF = mFault; nC = mCnt; nLp = mLp;
    if (!en) nF = 0;
    if (mState == M_FAULT && !en) nS = M_IDLE;
    if (v) begin
      if (!(freezeOnStop && (mState == M_IDLE || mState == M_FAULT)))
        nLp = sat16(mLp + (d >>> K_SHIFT));
      if (ov) begin
        nG = 0;
        if (en) begin nF = 1; nS = M_FAULT; end
        else nS = M_IDLE;
      end else if (mState == M_IDLE) begin
        if (en) begin nS = M_START; nG = 1; nC = 1; end
      end else if (mState == M_START || mState == M_RUN) begin
        if (!en) begin
          nS = M_STOP;
          if (!mGate || pn) begin nG = 0; nS = M_IDLE; end
        end else if (mState == M_RUN || mCnt >= len) begin
          nS = M_RUN;
          if (pp) nG = 1;
          else if (pn) nG = 0;
        end else nC = mCnt + 1;
      end else if (mState == M_STOP) begin
        if (!mGate || pn) begin nG = 0; nS = M_IDLE; end
      end
    end
    mState = nS; mGate = nG; mFault = nF; mCnt = nC; mLp = nLp;
  endtask

  // one clock: drive at negedge, predict, sample at next negedge
  task automatic step(bit v, int x, bit en, string req);
    sampleValid = v;
    sampleIn    = 12'(x);
    burstEn     = en;
    modelStep(v, x, en);
    @(posedge clk);
    @(negedge clk);
    check(req, "gateOut", int'(gateOut), int'(mGate));
    check(req, "faultOut", int'(faultOut), int'(mFault));
  endtask

  function automatic int clip12(int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int triWave(int i, int per, int amp);
    int ph;
    ph = i % per;
    if (ph < per/2) return -amp + (4*amp*ph)/per;
    return 3*amp - (4*amp*ph)/per;
  endfunction

  task automatic randBurst(string req, bit frz);
    int amp, per, onLen, total, x;
    amp   = 200 + $urandom_range(0, 1300);
    per   = 20 + $urandom_range(0, 40);
    onLen = 80 + $urandom_range(0, 200);
    total = onLen + 60 + $urandom_range(0, 60);
    freezeOnStop = frz;
    startLen = 16'($urandom_range(0, 30));
    leadCoef = 8'($urandom_range(0, 255));
    limitThr = ($urandom_range(0, 3) == 0) ? 12'(amp - $urandom_range(0, 100)) : 12'd4095;
    for (int i = 0; i < total; i++) begin
      x = clip12(triWave(i, per, amp) + $urandom_range(0, 16) - 8);
      step($urandom_range(0, 7) != 0, x, i < onLen, req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCH_CYC);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
  end

  initial begin
    void'($urandom(32'h1d5a7));
    rstN = 0; sampleValid = 0; sampleIn = '0; burstEn = 0;
    freezeOnStop = 0; startLen = 16'd4; leadCoef = 8'd0; limitThr = 12'd4095;
    mState = M_IDLE; mCnt = 0; mLp = 0; mGate = 0; mFault = 0;
    // R1: outputs low under reset even with a burst requested
    @(negedge clk);
    sampleValid = 1; burstEn = 1; sampleIn = 12'sd500;
    repeat (3) @(negedge clk);
    check("R1", "gateOut in reset", int'(gateOut), 0);
    check("R1", "faultOut in reset", int'(faultOut), 0);
    sampleValid = 0; burstEn = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "gateOut after reset", int'(gateOut), 0);
    check("R1", "faultOut after reset", int'(faultOut), 0);

    // R3: start pulse ignores a negative sample for startLen samples
    startLen = 16'd5;
    for (int i = 0; i < 5; i++) begin
      step(1, -1000, 1, "R3");
      check("R3", "pulse high", int'(gateOut), 1);
    end
    step(1, -1000, 1, "R4");
    check("R4", "off after pulse", int'(gateOut), 0);
    // R8: stop while off goes idle at once
    step(1, -1000, 0, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, 0, "R10");

    // R3: zero length counts as one sample
    startLen = 16'd0;
    step(1, -900, 1, "R3");
    check("R3", "zero-length pulse", int'(gateOut), 1);
    step(1, -900, 1, "R3");
    check("R3", "zero-length pulse end", int'(gateOut), 0);
    step(1, 0, 0, "R8");
    for (int i = 0; i < 20; i++) step(1, 0, 0, "R10");

    // R8: withdraw the burst while the gate is on; wait for the crossing
    startLen = 16'd2;
    for (int i = 0; i < 6; i++) step(1, 800, 1, "R4");
    for (int i = 0; i < 4; i++) begin
      step(1, 800, 0, "R8");
      check("R8", "held until crossing", int'(gateOut), 1);
    end
    // R2: no decision without a sample
    for (int i = 0; i < 4; i++) begin
      step(0, -1500, 0, "R2");
      check("R2", "quiet without valid", int'(gateOut), 1);
    end
    step(1, -800, 0, "R8");
    check("R8", "off at crossing", int'(gateOut), 0);
    step(1, 800, 0, "R8");
    check("R8", "no re-rise", int'(gateOut), 0);

    // R6, R7: limit trip, stickiness, clear
    limitThr = 12'd1500;
    for (int i = 0; i < 4; i++) step(1, 900, 1, "R4");
    step(1, -1500, 1, "R6");
    check("R6", "gate cut", int'(gateOut), 0);
    check("R6", "fault set", int'(faultOut), 1);
    for (int i = 0; i < 5; i++) begin
      step(1, 900, 1, "R7");
      check("R7", "fault sticky", int'(faultOut), 1);
      check("R7", "no restart", int'(gateOut), 0);
    end
    step(0, 0, 0, "R7");
    check("R7", "fault cleared", int'(faultOut), 0);
    // R6: limit with burst idle does not latch a fault
    step(1, 2047, 0, "R6");
    check("R6", "no fault when idle", int'(faultOut), 0);
    limitThr = 12'd4095;

    // R9: frozen filter across idle, then a strong-lead burst
    freezeOnStop = 1; leadCoef = 8'd255; startLen = 16'd3;
    for (int i = 0; i < 40; i++) step(1, 1200, 0, "R9");
    for (int i = 0; i < 30; i++) step(1, 1200 - 80*i, 1, "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 0, "R9");

    // R5: strong lead versus no lead on the same ramp
    freezeOnStop = 0;
    for (int c = 0; c < 2; c++) begin
      leadCoef = (c == 0) ? 8'd0 : 8'd200;
      for (int i = 0; i < 60; i++) step(1, 0, 0, "R10");
      for (int i = 0; i < 40; i++) step(1, 1000 - 50*i, 1, "R5");
      for (int i = 0; i < 20; i++) step(1, -1000, 0, "R5");
    end

    // random bursts, both filter modes
    for (int b = 0; b < 60; b++) begin
      if (b % 2 == 0) randBurst("R4", 1'b0);
      else            randBurst("R9", 1'b1);
    end
    summary();
  end

endmodule